// File: doc/BRIEF.md
# Table-Driven Sequencer with Condition Selection

This block is a finite state machine that holds no transition logic of its own. Its behaviour lives in a read-only lookup table. The table is filled at elaboration and never written afterwards. The current state code and the condition inputs together form the table address. The word read at each clock edge is split in two: one part is the next state code and the other part drives the decoded outputs. One or more parallel tables share the same address and supply extra decoded outputs.

The table read is synchronous. Its output register is the state register, so no other register lies between the inputs and the outputs. A parameter picks one of two addressing variants. In the direct variant, every condition input is an address bit. In the selected variant, a per-state selection table steers a multiplexer that reduces a wide condition bus to one address bit. This frees address width for more states.

The table gives a defined entry for every address, including those of spare codes that normal operation should never reach. Each spare code leads back to the recovery code in a single step, whatever the conditions are.

Top module: `rom_seq_top`

## Requirements
- R1: While `rst` is high at a clock edge, that edge loads state code 0, all-zero `dec_o` and all-zero `xtra_o`.
- R2: Direct variant (MUX_MODE=0). Take `rst` low, s = `state_o` and c = `cond_i` as an unsigned number, at a clock edge. If s < LEGAL, the state after that edge is (5*s + 3*c + SEED) mod 2^STATE_W.
- R3: `dec_o` comes from the same table word as the state, in the same cycle. For a legal s it is (s XOR (c*2)) mod 2^DEC_W.
- R4: At a clock edge with s >= LEGAL (a spare code), the next state is 0 and `dec_o` becomes all ones, for every condition value.
- R5: Selected variant (MUX_MODE=1). The address bit c is `cond_i[k]` with k = (3*s + SEED) mod COND_W. The other condition inputs have no effect. R2, R3, R4 and R6 then apply with this one-bit c.
- R6: A parallel table on the same address drives `xtra_o`. It is (s + 7*c) mod 2^XTRA_W for a legal s and 0 for a spare s.
- R7: A reset pulse in the middle of operation takes priority over the table word at that edge. The sequence restarts from code 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | COND_W | Condition inputs |
| state_o | output | STATE_W | Current state code (the table output register) |
| dec_o | output | DEC_W | Decoded outputs from the main table word |
| xtra_o | output | XTRA_W | Decoded outputs from the parallel table |

## Verification
Two functions can land on the same edge: a spare-code recovery jump and the ordinary condition-driven lookup. Another pair is a reset pulse and a table load. The bench steers the conditions on purpose so that a legal state jumps into a spare code. It then applies random conditions during the recovery cycle. The result must be code 0 with the fault pattern on `dec_o`, no matter what the conditions were. A reset pulse is also dropped in the middle of a run, and the state must read code 0 instead of the table word. A behavioural model compares all outputs of both variants on every cycle, and in the selected variant it looks only at the chosen condition bit.

// File: rtl/rom_seq_pkg.sv
package rom_seq_pkg;

  // Main table word: {next_state, decoded} for one address.
  function automatic int main_entry(int addr, int cbits, int dw, int sw,
                                    int legal, int seed);
    int s;
    int c;
    int nxt;
    int dec;
    s = addr >> cbits;
    c = addr & ((1 << cbits) - 1);
    if (s >= legal) begin
      nxt = 0;
      dec = (1 << dw) - 1;
    end else begin
      nxt = (5 * s + 3 * c + seed) % (1 << sw);
      dec = (s ^ (c << 1)) % (1 << dw);
    end
    return (nxt << dw) | dec;
  endfunction

  // Parallel table word for the same address.
  function automatic int xtra_entry(int addr, int cbits, int xw, int legal);
    int s;
    int c;
    s = addr >> cbits;
    c = addr & ((1 << cbits) - 1);
    if (s >= legal) return 0;
    return (s + 7 * c) % (1 << xw);
  endfunction

  // Condition index chosen by a state in the selected variant.
  function automatic int sel_entry(int s, int seed, int n);
    return (3 * s + seed) % n;
  endfunction

endpackage

// File: rtl/rom_seq_bank.sv
module rom_seq_bank #(
  parameter int AW    = 9,
  parameter int DW    = 8,
  parameter int KIND  = 0,
  parameter int CBITS = 4,
  parameter int SW    = 5,
  parameter int SUBW  = 3,
  parameter int LEGAL = 24,
  parameter int SEED  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word_nx,
  output logic [DW-1:0] word_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      if (KIND == 0)
        mem[a] = DW'(rom_seq_pkg::main_entry(a, CBITS, SUBW, SW, LEGAL, SEED));
      else
        mem[a] = DW'(rom_seq_pkg::xtra_entry(a, CBITS, DW, LEGAL));
    end
  end

  assign word_nx = mem[addr];

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_nx;
  end
endmodule

// File: rtl/rom_seq_csel.sv
module rom_seq_csel #(
  parameter int STATE_W = 7,
  parameter int COND_W  = 8,
  parameter int SEED    = 3
) (
  input  logic [STATE_W-1:0] state,
  input  logic [COND_W-1:0]  cond,
  output logic               cond_bit
);
  localparam int NST   = 1 << STATE_W;
  localparam int SEL_W = (COND_W > 1) ? $clog2(COND_W) : 1;

  logic [SEL_W-1:0] sel_tbl [NST];
  logic [SEL_W-1:0] sel_idx;

  initial begin
    for (int s = 0; s < NST; s++)
      sel_tbl[s] = SEL_W'(rom_seq_pkg::sel_entry(s, SEED, COND_W));
  end

  assign sel_idx  = sel_tbl[state];
  assign cond_bit = cond[sel_idx];
endmodule

// File: rtl/rom_seq_top.sv
module rom_seq_top #(
  parameter int STATE_W  = 5,
  parameter int COND_W   = 4,
  parameter int DEC_W    = 3,
  parameter int XTRA_W   = 4,
  parameter int MUX_MODE = 0,
  parameter int LEGAL    = 24,
  parameter int SEED     = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COND_W-1:0]  cond_i,
  output logic [STATE_W-1:0] state_o,
  output logic [DEC_W-1:0]   dec_o,
  output logic [XTRA_W-1:0]  xtra_o
);
  localparam int CBITS  = (MUX_MODE != 0) ? 1 : COND_W;
  localparam int AW     = STATE_W + CBITS;
  localparam int WORD_W = STATE_W + DEC_W;

  logic [CBITS-1:0]  addr_cond;
  logic [AW-1:0]     tbl_addr;
  logic [WORD_W-1:0] tbl_next;
  logic [WORD_W-1:0] tbl_q;
  logic [XTRA_W-1:0] xtra_next;
  logic              spare_now;

  generate
    if (MUX_MODE != 0) begin : g_sel
      logic cbit;
      rom_seq_csel #(.STATE_W(STATE_W), .COND_W(COND_W), .SEED(SEED)) u_csel (
        .state(state_o), .cond(cond_i), .cond_bit(cbit));
      assign addr_cond = cbit;
    end else begin : g_direct
      assign addr_cond = cond_i;
    end
  endgenerate

  assign tbl_addr = {state_o, addr_cond};

  rom_seq_bank #(.AW(AW), .DW(WORD_W), .KIND(0), .CBITS(CBITS), .SW(STATE_W),
                 .SUBW(DEC_W), .LEGAL(LEGAL), .SEED(SEED)) u_main (
    .clk(clk), .rst(rst), .addr(tbl_addr), .word_nx(tbl_next), .word_q(tbl_q));

  rom_seq_bank #(.AW(AW), .DW(XTRA_W), .KIND(1), .CBITS(CBITS), .SW(STATE_W),
                 .SUBW(DEC_W), .LEGAL(LEGAL), .SEED(SEED)) u_xtra (
    .clk(clk), .rst(rst), .addr(tbl_addr), .word_nx(xtra_next), .word_q(xtra_o));

  assign state_o   = tbl_q[WORD_W-1:DEC_W];
  assign dec_o     = tbl_q[DEC_W-1:0];
  assign spare_now = int'(state_o) >= LEGAL;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (state_o == '0 && dec_o == '0 && xtra_o == '0));

  // R2
  word_load_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tbl_q == $past(tbl_next) && xtra_o == $past(xtra_next)));

  // R4
  spare_recover_chk: assert property (@(posedge clk) disable iff (rst)
    spare_now |=> (state_o == '0));

  // R4
  spare_flag_chk: assert property (@(posedge clk) disable iff (rst)
    spare_now |=> (dec_o == '1 && xtra_o == '0));
endmodule

// File: tb/rom_seq_top_test.sv
module rom_seq_top_test;
  localparam int CLK_NS = 10;

  localparam int A_LEG = 24, A_SEED = 1;
  localparam int B_LEG = 100, B_SEED = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] cond_a = '0;
  logic [7:0] cond_b = '0;
  logic [4:0] st_a;
  logic [2:0] dec_a;
  logic [3:0] xt_a;
  logic [6:0] st_b;
  logic [2:0] dec_b;
  logic [1:0] xt_b;

  int checks = 0;
  int fails = 0;
  int spare_a = 0;
  int spare_b = 0;
  logic [31:0] rng = 32'h1234_5678;

  // model state
  int ms_a = 0, md_a = 0, mx_a = 0, ms_b = 0, md_b = 0, mx_b = 0;
  bit pspare_a = 0, pspare_b = 0, prst = 0;

  always #(CLK_NS/2) clk = ~clk;

  rom_seq_top uut (.clk(clk), .rst(rst), .cond_i(cond_a),
    .state_o(st_a), .dec_o(dec_a), .xtra_o(xt_a));

  rom_seq_top #(.STATE_W(7), .COND_W(8), .DEC_W(3), .XTRA_W(2), .MUX_MODE(1),
                .LEGAL(B_LEG), .SEED(B_SEED)) uut_mx (
    .clk(clk), .rst(rst), .cond_i(cond_b),
    .state_o(st_b), .dec_o(dec_b), .xtra_o(xt_b));

  function automatic int nx_a(int s, int c);
    if (s >= A_LEG) return 0;
    return ((s << 2) + s + (c << 1) + c + A_SEED) & 31;
  endfunction

  function automatic int pick_b(int s, logic [7:0] cv);
    int k;
    k = ((s << 1) + s + B_SEED) & 7;
    return int'(cv[k]);
  endfunction

  function automatic int nx_b(int s, int c);
    if (s >= B_LEG) return 0;
    return ((s << 2) + s + (c << 1) + c + B_SEED) & 127;
  endfunction

  always @(posedge clk) begin
    int cb;
    prst = rst;
    pspare_a = ms_a >= A_LEG;
    pspare_b = ms_b >= B_LEG;
    if (rst) begin
      ms_a = 0; md_a = 0; mx_a = 0; ms_b = 0; md_b = 0; mx_b = 0;
    end else begin
      if (pspare_a) begin md_a = 7; mx_a = 0; end
      else begin md_a = (ms_a ^ (int'(cond_a) * 2)) & 7; mx_a = (ms_a + 7 * int'(cond_a)) & 15; end
      ms_a = nx_a(ms_a, int'(cond_a));
      cb = pick_b(ms_b, cond_b);
      if (pspare_b) begin md_b = 7; mx_b = 0; end
      else begin md_b = (ms_b ^ (cb * 2)) & 7; mx_b = (ms_b + 7 * cb) & 3; end
      ms_b = nx_b(ms_b, cb);
      if (pspare_a) spare_a++;
      if (pspare_b) spare_b++;
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all(bit mid_reset);
    string ts;
    ts = prst ? (mid_reset ? "R7" : "R1") : (pspare_a ? "R4" : "R2");
    chk({ts, " state"}, int'(st_a), ms_a);
    chk(prst ? {ts, " dec"} : (pspare_a ? "R4 dec" : "R3 dec"), int'(dec_a), md_a);
    chk(prst ? {ts, " xtra"} : "R6 xtra", int'(xt_a), mx_a);
    chk(prst ? {ts, " mux state"} : (pspare_b ? "R4 mux state" : "R5 mux state"),
        int'(st_b), ms_b);
    chk("R5 mux dec", int'(dec_b), md_b);
    chk("R6 mux xtra", int'(xt_b), mx_b);
  endtask

  function automatic logic [31:0] step(logic [31:0] v);
    logic [31:0] x;
    x = v ^ (v << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic run_cycles(int n, bit steer, bit mid_reset);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all(mid_reset);
      rng = step(rng);
      cond_a = rng[3:0];
      cond_b = rng[15:8];
      if (steer) begin
        for (int c = 0; c < 16; c++)
          if (nx_a(ms_a, c) >= A_LEG) cond_a = 4'(c);
        begin
          int k;
          k = ((ms_b << 1) + ms_b + B_SEED) & 7;
          if (nx_b(ms_b, 1) >= B_LEG || nx_b(ms_b, 1) > nx_b(ms_b, 0))
            cond_b[k] = 1'b1;
          else
            cond_b[k] = 1'b0;
        end
      end
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    compare_all(1'b0);              // R1 reset values
    rst = 1'b0;
    run_cycles(300, 1'b0, 1'b0);    // R2 R3 R5 R6 random conditions
    run_cycles(200, 1'b1, 1'b0);    // R4 steered into spare codes
    @(negedge clk);
    compare_all(1'b0);
    rst = 1'b1;                     // R7 reset pulse mid-run
    @(negedge clk);
    compare_all(1'b1);
    rst = 1'b0;
    run_cycles(60, 1'b0, 1'b0);
    checks++;
    if (spare_a == 0) begin fails++; $display("FAIL R4 direct spare visits got %0d expected >0", spare_a); end
    checks++;
    if (spare_b == 0) begin fails++; $display("FAIL R4 mux spare visits got %0d expected >0", spare_b); end
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule